// File: doc/BRIEF.md
# Single-Cycle Opcode Prefix Detector

This block sits beside a small 8-bit processor and watches every opcode fetch on the data bus. A fetch-strobe input is high in each cycle in which the processor reads an opcode. When the fetched byte comes from the family of one-byte, one-cycle no-operation opcodes, the block emits a trigger pulse one cycle later together with the captured byte. Downstream logic can then decode which variant fired. Two values that match the bit pattern but are really the wait and stop instructions are never detected.

Candidates with low nibble 7 or F also act as prefixes. They open a bank window that covers exactly the next instruction: `bank_sel` rises in the fetch cycle of that instruction and stays high while it runs. It drops in the cycle of the fetch that follows. `bank_code` carries the prefix byte for the memory decoder. Candidates with low nibble 3 or B only pulse the trigger.

The window is a three-state machine. IDLE moves to ARMED on a prefix fetch. ARMED stays put while the strobe is low. On a fetch, ARMED moves to ACTIVE, or back to ARMED with the new code if that fetch is another prefix. ACTIVE stays put while the strobe is low. On a fetch, ACTIVE returns to IDLE, or moves to ARMED if that fetch is a prefix. Reset enters IDLE.

Top module: `nop_prefix_det`

## Requirements
- R1: A byte with bits [1:0] = 11 fetched with `fetch_strobe` high produces `trig_pulse` = 1 in the next cycle, with `trig_code` equal to that byte.
- R2: Bus bytes seen while `fetch_strobe` is low never cause a trigger or a bank window.
- R3: The bytes 0xCB and 0xDB are not detected: no trigger pulse and no bank window.
- R4: Each detected fetch gives a pulse of exactly one cycle, so back-to-back detected fetches give pulses in consecutive cycles. `trig_code` keeps the last detected byte while no pulse is present.
- R5: Only candidates with bit 2 = 1 (low nibble 7 or F) open a bank window. Candidates with bit 2 = 0 (low nibble 3 or B) only trigger.
- R6: After a prefix fetch, `bank_sel` is high from the next cycle (the following fetch) through every non-fetch cycle of that instruction. It is low in the fetch cycle after that, which holds both for single-cycle and for multi-cycle followers.
- R7: A prefix fetched while a window is open re-arms the window for the instruction after it, and `bank_code` changes to the new byte. Windows never stack.
- R8: `bank_code` equals the active prefix byte while `bank_sel` is high and is 0 otherwise.
- R9: During and after reset, `trig_pulse` and `bank_sel` are 0 until a qualifying fetch occurs, and `trig_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_strobe | input | 1 | High in opcode fetch cycles |
| bus_data | input | 8 | Processor data bus |
| trig_pulse | output | 1 | One-cycle pulse after a detected fetch |
| trig_code | output | 8 | Last detected opcode byte |
| bank_sel | output | 1 | Bank window active |
| bank_code | output | 8 | Prefix byte of the open window, else 0 |

## Verification
Trigger-class bytes (0x03, 0xFB) in adjacent fetches show that pulses are per fetch and that the code is held afterwards. The same pattern bytes presented without the strobe, and the wait and stop bytes presented with it, separate pattern matching from qualification and exclusion. Prefix bytes followed by a one-cycle and by a multi-cycle instruction show that the window ends on the next fetch and not after a fixed count. Two prefixes in a row show re-arming with the new code.

// File: rtl/nopx_pkg.sv
package nopx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ACTIVE = 2'd2
    } win_state_t;
endpackage

// File: rtl/nopx_classify.sv
module nopx_classify #(
    parameter int          OPW    = 8,
    parameter logic [7:0]  EXCL_A = 8'hCB,
    parameter logic [7:0]  EXCL_B = 8'hDB,
    parameter int          PBIT   = 2
) (
    input  logic           strobe,
    input  logic [OPW-1:0] op,
    output logic           hit_any,
    output logic           hit_pre
);
    logic pattern;
    logic excluded;

    always_comb begin
        pattern  = (op[1:0] == 2'b11);
        excluded = (op == OPW'(EXCL_A)) || (op == OPW'(EXCL_B));
        hit_any  = strobe && pattern && !excluded;
        hit_pre  = hit_any && op[PBIT];
    end
endmodule

// File: rtl/nopx_trigger.sv
module nopx_trigger #(
    parameter int OPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hit_any,
    input  logic [OPW-1:0] op,
    output logic           pulse,
    output logic [OPW-1:0] code
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            code  <= '0;
        end else begin
            pulse <= hit_any;
            if (hit_any) begin
                code <= op;
            end
        end
    end
endmodule

// File: rtl/nopx_window.sv
module nopx_window
    import nopx_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe,
    input  logic           hit_pre,
    input  logic [OPW-1:0] op,
    output logic           win_on,
    output logic [OPW-1:0] win_code
);
    win_state_t     st_q, st_d;
    logic [OPW-1:0] code_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (hit_pre) st_d = ST_ARMED;
            ST_ARMED:  if (strobe)  st_d = hit_pre ? ST_ARMED : ST_ACTIVE;
            ST_ACTIVE: if (strobe)  st_d = hit_pre ? ST_ARMED : ST_IDLE;
            default:                st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            code_q <= '0;
        end else begin
            st_q <= st_d;
            if (hit_pre) begin
                code_q <= op;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            ST_ARMED:  win_on = 1'b1;
            ST_ACTIVE: win_on = !strobe;
            default:   win_on = 1'b0;
        endcase
        win_code = win_on ? code_q : '0;
    end
endmodule

// File: rtl/nop_prefix_det.sv
module nop_prefix_det #(
    parameter int         OPW    = 8,
    parameter logic [7:0] EXCL_A = 8'hCB,
    parameter logic [7:0] EXCL_B = 8'hDB,
    parameter int         PBIT   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fetch_strobe,
    input  logic [OPW-1:0] bus_data,
    output logic           trig_pulse,
    output logic [OPW-1:0] trig_code,
    output logic           bank_sel,
    output logic [OPW-1:0] bank_code
);
    logic hit_any;
    logic hit_pre;

    nopx_classify #(.OPW(OPW), .EXCL_A(EXCL_A), .EXCL_B(EXCL_B), .PBIT(PBIT)) u_cls (
        .strobe  (fetch_strobe),
        .op      (bus_data),
        .hit_any (hit_any),
        .hit_pre (hit_pre)
    );

    nopx_trigger #(.OPW(OPW)) u_trg (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_any (hit_any),
        .op      (bus_data),
        .pulse   (trig_pulse),
        .code    (trig_code)
    );

    nopx_window #(.OPW(OPW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (fetch_strobe),
        .hit_pre  (hit_pre),
        .op       (bus_data),
        .win_on   (bank_sel),
        .win_code (bank_code)
    );
endmodule

// File: rtl/nop_prefix_det_chk.sv
module nop_prefix_det_chk #(
    parameter int OPW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fetch_strobe,
    input logic           trig_pulse,
    input logic [OPW-1:0] trig_code,
    input logic           bank_sel,
    input logic [OPW-1:0] bank_code
);
    a_r2_pulse_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(fetch_strobe));

    a_r3_no_excluded_code: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> (trig_code[1:0] == 2'b11 && trig_code != 8'hCB && trig_code != 8'hDB));

    a_r6_open_fetch_is_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_strobe && bank_sel) |-> (trig_code[2] && trig_code[1:0] == 2'b11));

    a_r5_rise_after_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_sel) |-> (trig_pulse && trig_code[2]));

    a_r8_code_zero_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_sel |-> (bank_code == '0));

    a_r8_code_matches_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel |-> (bank_code[1:0] == 2'b11 && bank_code[2]));
endmodule

bind nop_prefix_det nop_prefix_det_chk #(.OPW(OPW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_strobe (fetch_strobe),
    .trig_pulse   (trig_pulse),
    .trig_code    (trig_code),
    .bank_sel     (bank_sel),
    .bank_code    (bank_code)
);

// File: tb/sim_nop_prefix_det.sv
`timescale 1ns/1ps
module sim_nop_prefix_det;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch_strobe = 1'b0;
    logic [7:0] bus_data = 8'h00;
    logic       trig_pulse;
    logic [7:0] trig_code;
    logic       bank_sel;
    logic [7:0] bank_code;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nop_prefix_det u0 (
        .clk(clk), .rst_n(rst_n), .fetch_strobe(fetch_strobe), .bus_data(bus_data),
        .trig_pulse(trig_pulse), .trig_code(trig_code),
        .bank_sel(bank_sel), .bank_code(bank_code)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs; outputs of that cycle are valid on return
    task automatic drive(input logic s, input logic [7:0] d);
        @(negedge clk);
        fetch_strobe = s;
        bus_data     = d;
        #1;
    endtask

    task automatic settle();
        drive(1'b1, 8'hEA);
        drive(1'b0, 8'h00);
    endtask

    task automatic t_reset();
        drive(1'b1, 8'h07);
        chk("R9 pulse in reset", {7'd0, trig_pulse}, 8'd0);
        chk("R9 bank in reset", {7'd0, bank_sel}, 8'd0);
        drive(1'b0, 8'h00);
        rst_n = 1'b1;
        drive(1'b0, 8'h00);
        chk("R9 pulse after reset", {7'd0, trig_pulse}, 8'd0);
        chk("R9 code after reset", trig_code, 8'h00);
        chk("R9 bank after reset", {7'd0, bank_sel}, 8'd0);
    endtask

    task automatic t_trigger_only();
        drive(1'b1, 8'h03);
        drive(1'b1, 8'hFB);
        chk("R1 pulse 03", {7'd0, trig_pulse}, 8'd1);
        chk("R1 code 03", trig_code, 8'h03);
        chk("R5 no bank for 03", {7'd0, bank_sel}, 8'd0);
        drive(1'b1, 8'hEA);
        chk("R4 back-to-back pulse", {7'd0, trig_pulse}, 8'd1);
        chk("R4 code FB", trig_code, 8'hFB);
        chk("R5 no bank for FB", {7'd0, bank_sel}, 8'd0);
        drive(1'b0, 8'h00);
        chk("R4 pulse one cycle", {7'd0, trig_pulse}, 8'd0);
        chk("R4 code held", trig_code, 8'hFB);
    endtask

    task automatic t_no_strobe();
        drive(1'b0, 8'h07);
        drive(1'b0, 8'h33);
        chk("R2 no pulse w/o strobe", {7'd0, trig_pulse}, 8'd0);
        chk("R2 no bank w/o strobe", {7'd0, bank_sel}, 8'd0);
        drive(1'b0, 8'h00);
        chk("R2 no pulse second", {7'd0, trig_pulse}, 8'd0);
        chk("R2 code unchanged", trig_code, 8'hFB);
    endtask

    task automatic t_excluded();
        drive(1'b1, 8'hCB);
        drive(1'b0, 8'h00);
        chk("R3 CB no pulse", {7'd0, trig_pulse}, 8'd0);
        drive(1'b1, 8'hDB);
        drive(1'b1, 8'hEA);
        chk("R3 DB no pulse", {7'd0, trig_pulse}, 8'd0);
        chk("R3 DB no bank", {7'd0, bank_sel}, 8'd0);
        chk("R3 code unchanged", trig_code, 8'hFB);
    endtask

    task automatic t_prefix_long();
        drive(1'b1, 8'h07);
        chk("R6 bank low at prefix fetch", {7'd0, bank_sel}, 8'd0);
        drive(1'b1, 8'hAD);
        chk("R6 bank at follower fetch", {7'd0, bank_sel}, 8'd1);
        chk("R8 bank code 07", bank_code, 8'h07);
        chk("R1 prefix pulses", {7'd0, trig_pulse}, 8'd1);
        drive(1'b0, 8'h34);
        chk("R6 bank during follower", {7'd0, bank_sel}, 8'd1);
        drive(1'b0, 8'h12);
        chk("R6 bank still during follower", {7'd0, bank_sel}, 8'd1);
        drive(1'b1, 8'hEA);
        chk("R6 bank low at next fetch", {7'd0, bank_sel}, 8'd0);
        chk("R8 code zero closed", bank_code, 8'h00);
        drive(1'b0, 8'h00);
        chk("R6 stays low", {7'd0, bank_sel}, 8'd0);
    endtask

    task automatic t_prefix_short();
        drive(1'b1, 8'h0F);
        drive(1'b1, 8'hEA);
        chk("R6 short bank on", {7'd0, bank_sel}, 8'd1);
        chk("R8 short code 0F", bank_code, 8'h0F);
        drive(1'b1, 8'hA9);
        chk("R6 short bank off", {7'd0, bank_sel}, 8'd0);
        chk("R8 short code zero", bank_code, 8'h00);
        drive(1'b0, 8'h00);
    endtask

    task automatic t_rearm();
        drive(1'b1, 8'h17);
        drive(1'b1, 8'h27);
        chk("R7 first window", {7'd0, bank_sel}, 8'd1);
        chk("R7 first code", bank_code, 8'h17);
        drive(1'b1, 8'hAD);
        chk("R7 rearmed on", {7'd0, bank_sel}, 8'd1);
        chk("R7 new code", bank_code, 8'h27);
        chk("R7 pulse second prefix", trig_code, 8'h27);
        drive(1'b0, 8'h00);
        chk("R7 window through follower", bank_code, 8'h27);
        drive(1'b1, 8'hEA);
        chk("R7 single window ends", {7'd0, bank_sel}, 8'd0);
        drive(1'b0, 8'h00);
    endtask

    initial begin
        t_reset();
        t_trigger_only();
        t_no_strobe();
        t_excluded();
        settle();
        t_prefix_long();
        t_prefix_short();
        t_rearm();
        settle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule